// File: doc/BRIEF.md
# Reduced-Complexity Hard-Bit/Magnitude LDPC Decoder

This block decodes one frame of a small quasi-cyclic LDPC code. The parity-check matrix is built into the logic. Every variable node holds only a hard decision bit and an unsigned reliability. A check node sends each of its neighbours two things: an attenuated minimum of the other neighbours' reliabilities, and the XOR of the other neighbours' hard bits. Because of this the arithmetic needs nothing beyond adders, comparators, shifts and XOR gates. No full soft messages are stored on the edges.

A frame of sign-magnitude channel LLRs is presented in parallel and a one-cycle start pulse is given while the block is idle. The block then runs a check phase, a variable phase and a syndrome test once per iteration. It stops when every parity check is satisfied or when the iteration cap is reached. It raises a one-cycle done pulse and holds the decoded bits and a converged flag until the next accepted start.

Top module: `rcapp_decoder`

## Requirements
- R1: While reset is low, and in the cycles that follow its release, busy, done, converged and every bit of bits_out are 0.
- R2: A start pulse is taken only when busy is low. A start given while a frame is in progress is ignored, together with its LLRs, and has no effect on that frame's timing or result.
- R3: Each LLR occupies bits [4v+3:4v] of llr_in for variable v. Bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude. The initial hard bit equals the sign bit and the initial reliability equals the magnitude.
- R4: The reliability a check sends to one neighbour is round(0.375·x), computed as (3x+4)>>3, where x is the smallest current reliability among that check's other neighbours.
- R5: The parity a check sends to one neighbour is the XOR of the current hard bits of its other neighbours. That vote adds its reliability when the parity equals the neighbour's channel sign bit and subtracts it otherwise.
- R6: A variable's new total is its channel magnitude plus its three votes. The new hard bit is the channel sign bit XOR (total < 0). The new reliability is |total| saturated to 15.
- R7: With P=5, check i·5+a (block row i<3) connects, for each block column j<5, to variable j·5+((a+i·j) mod 5).
- R8: The syndrome of the hard bits is tested after each iteration. If it is zero, done pulses with converged=1 exactly 1+3k cycles after the accepting clock edge, where k is the number of iterations run.
- R9: If the syndrome is still nonzero after MAX_ITER (default 8) iterations, done pulses with converged=0 exactly 1+3·MAX_ITER cycles after the accepting edge.
- R10: busy is high from the cycle after the accepting edge through the done cycle. done lasts one cycle. bits_out and converged hold their final values while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin decoding the frame on llr_in (honoured only when idle) |
| llr_in | input | 100 | 25 sign-magnitude 4-bit channel LLRs |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-decode pulse |
| converged | output | 1 | Final syndrome was zero |
| bits_out | output | 25 | Decoded hard bits, bit v for variable v |

## Verification
Take the clock edge that accepts start as edge 0. The decoder goes to initialisation on that edge and loads its reliabilities on edge 1. Each later iteration costs three edges, so done and the final converged value are due 1+3k edges after acceptance, and busy falls one edge after that. The bench's reference model counts edges from the accepting edge in exactly this way. It samples every output on the falling edge, so busy, done and converged are compared on every cycle. bits_out is compared at the done cycle and on every idle cycle that follows.

// File: rtl/rcapp_pkg.sv
// Package: shared state encoding and the fixed circulant wiring of the
// parity-check matrix. Assumes P is prime and the shift of block (i,j)
// is i*j mod P, which keeps short cycles out of the Tanner graph.
package rcapp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_CHK, ST_VAR, ST_SYN, ST_DONE
    } dec_state_t;

    // Variable index reached by edge j of check slot a in block row i.
    function automatic int var_of(input int i, input int j, input int a, input int p);
        return j * p + ((a + i * j) % p);
    endfunction

    // Check slot within block row i that touches position b of block column j.
    function automatic int slot_of(input int i, input int j, input int b, input int p);
        return (b - ((i * j) % p) + p) % p;
    endfunction

endpackage

// File: rtl/rcapp_check_unit.sv
// Check node: from the hard bits and reliabilities of its C neighbours it
// forms, per edge, the attenuated minimum of the others and the XOR of the
// others. These are registered when en is high. par_all is the
// combinational parity of all neighbours (one syndrome bit).
module rcapp_check_unit #(
    parameter int C     = 5,
    parameter int MAG_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [C-1:0]               z_in,
    input  logic [C-1:0][MAG_W-1:0]    m_in,
    output logic [C-1:0][MAG_W-1:0]    mag_q,
    output logic [C-1:0]               par_q,
    output logic                       par_all
);

    localparam int TW = MAG_W + 2;

    logic [C-1:0][MAG_W-1:0] mag_n;
    logic [C-1:0]            par_n;

    // Parity over all neighbours, reused as the syndrome bit.
    always_comb par_all = ^z_in;

    // Per-edge exclusive minimum scaled by 3/8 with rounding, plus exclusive parity.
    always_comb begin
        for (int j = 0; j < C; j++) begin
            logic [MAG_W-1:0] mn;
            logic [TW-1:0]    tri3;
            mn = '1;
            for (int k = 0; k < C; k++) begin
                if (k != j && m_in[k] < mn) mn = m_in[k];
            end
            tri3     = TW'(mn) + TW'({mn, 1'b0}) + TW'(4);
            mag_n[j] = MAG_W'(tri3 >> 3);
            par_n[j] = par_all ^ z_in[j];
        end
    end

    // Edge message registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            par_q <= '0;
        end else if (en) begin
            mag_q <= mag_n;
            par_q <= par_n;
        end
    end

endmodule

// File: rtl/rcapp_var_unit.sv
// Variable node: keeps a hard bit and a saturating reliability. On init it
// loads both from the channel LLR (sign-magnitude). On en it adds the
// channel magnitude and R signed votes. The hard bit becomes channel sign
// XOR (sum<0) and the reliability becomes |sum| saturated.
// Assumes LLR_W-1 <= MAG_W.
module rcapp_var_unit #(
    parameter int R     = 3,
    parameter int MAG_W = 4,
    parameter int LLR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       init,
    input  logic                       en,
    input  logic [LLR_W-1:0]           llr,
    input  logic [R-1:0][MAG_W-1:0]    vmag,
    input  logic [R-1:0]               vpar,
    output logic                       z_q,
    output logic [MAG_W-1:0]           m_q
);

    localparam int SW = MAG_W + $clog2(R + 1) + 1;

    logic             ch_bit;
    logic [LLR_W-2:0] ch_mag;
    logic [SW-1:0]    acc;
    logic [SW-1:0]    absv;
    logic             neg;
    logic [MAG_W-1:0] sat;

    assign ch_bit = llr[LLR_W-1];
    assign ch_mag = llr[LLR_W-2:0];

    // Channel magnitude plus agreeing votes minus disagreeing votes.
    always_comb begin
        acc = SW'(ch_mag);
        for (int r = 0; r < R; r++) begin
            if (vpar[r] == ch_bit) acc = acc + SW'(vmag[r]);
            else                   acc = acc - SW'(vmag[r]);
        end
        neg  = acc[SW-1];
        absv = neg ? (~acc + SW'(1)) : acc;
        sat  = (|absv[SW-1:MAG_W]) ? '1 : absv[MAG_W-1:0];
    end

    // Hard bit and reliability registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= 1'b0;
            m_q <= '0;
        end else if (init) begin
            z_q <= ch_bit;
            m_q <= MAG_W'(ch_mag);
        end else if (en) begin
            z_q <= ch_bit ^ neg;
            m_q <= sat;
        end
    end

endmodule

// File: rtl/rcapp_ctrl.sv
// Sequencer: idle -> load -> (check -> variable -> syndrome)* -> done.
// One cycle per state for the whole frame. Stops on a zero syndrome or
// after MAX_ITER iterations and records whether the syndrome was zero.
module rcapp_ctrl
    import rcapp_pkg::*;
#(
    parameter int MAX_ITER = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic synd_zero,
    output logic capture,
    output logic init,
    output logic chk_en,
    output logic var_en,
    output logic busy,
    output logic done,
    output logic converged
);

    localparam int IT_W = $clog2(MAX_ITER + 1);
    localparam logic [IT_W-1:0] LAST_IT = IT_W'(MAX_ITER - 1);

    dec_state_t      state, state_n;
    logic [IT_W-1:0] iter;

    // Phase strobes decoded from the state.
    always_comb begin
        capture = (state == ST_IDLE) && start;
        init    = (state == ST_LOAD);
        chk_en  = (state == ST_CHK);
        var_en  = (state == ST_VAR);
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
    end

    // Next-state selection.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (start) state_n = ST_LOAD;
            ST_LOAD: state_n = ST_CHK;
            ST_CHK:  state_n = ST_VAR;
            ST_VAR:  state_n = ST_SYN;
            ST_SYN:  state_n = (synd_zero || iter == LAST_IT) ? ST_DONE : ST_CHK;
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // State, iteration counter and converged flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            iter      <= '0;
            converged <= 1'b0;
        end else begin
            state <= state_n;
            if (capture) begin
                iter      <= '0;
                converged <= 1'b0;
            end else if (state == ST_SYN) begin
                iter <= iter + IT_W'(1);
                if (synd_zero) converged <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rcapp_decoder.sv
// Top: reduced-complexity LDPC decoder for a P*R by P*C quasi-cyclic code.
// Captures the LLR frame on an accepted start, runs all check nodes in one
// cycle and all variable nodes in the next, then tests the syndrome.
// Assumes a fully parallel datapath is affordable for the small default code.
module rcapp_decoder
    import rcapp_pkg::*;
#(
    parameter int P        = 5,
    parameter int R        = 3,
    parameter int C        = 5,
    parameter int LLR_W    = 4,
    parameter int MAG_W    = 4,
    parameter int MAX_ITER = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [P*C*LLR_W-1:0]   llr_in,
    output logic                   busy,
    output logic                   done,
    output logic                   converged,
    output logic [P*C-1:0]         bits_out
);

    localparam int N = P * C;
    localparam int M = P * R;

    logic                         capture, init, chk_en, var_en;
    logic [N*LLR_W-1:0]           llr_q;
    logic [N-1:0]                 z_q;
    logic [N-1:0][MAG_W-1:0]      m_q;
    logic [M-1:0][C-1:0]          chk_z;
    logic [M-1:0][C-1:0][MAG_W-1:0] chk_m;
    logic [M-1:0][C-1:0][MAG_W-1:0] edge_mag;
    logic [M-1:0][C-1:0]          edge_par;
    logic [M-1:0]                 synd;
    logic [N-1:0][R-1:0][MAG_W-1:0] vin_mag;
    logic [N-1:0][R-1:0]          vin_par;

    // Frame capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)       llr_q <= '0;
        else if (capture) llr_q <= llr_in;
    end

    rcapp_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .synd_zero (~|synd),
        .capture   (capture),
        .init      (init),
        .chk_en    (chk_en),
        .var_en    (var_en),
        .busy      (busy),
        .done      (done),
        .converged (converged)
    );

    // Check nodes: one per row of the parity-check matrix.
    for (genvar i = 0; i < R; i++) begin : g_brow
        for (genvar a = 0; a < P; a++) begin : g_slot
            localparam int CI = i * P + a;
            for (genvar j = 0; j < C; j++) begin : g_edge
                localparam int VI = var_of(i, j, a, P);
                assign chk_z[CI][j] = z_q[VI];
                assign chk_m[CI][j] = m_q[VI];
            end
            rcapp_check_unit #(.C(C), .MAG_W(MAG_W)) u_chk (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (chk_en),
                .z_in    (chk_z[CI]),
                .m_in    (chk_m[CI]),
                .mag_q   (edge_mag[CI]),
                .par_q   (edge_par[CI]),
                .par_all (synd[CI])
            );
        end
    end

    // Variable nodes: one per column, fed by one edge per block row.
    for (genvar j = 0; j < C; j++) begin : g_bcol
        for (genvar b = 0; b < P; b++) begin : g_pos
            localparam int VI = j * P + b;
            for (genvar i = 0; i < R; i++) begin : g_in
                localparam int CI = i * P + slot_of(i, j, b, P);
                assign vin_mag[VI][i] = edge_mag[CI][j];
                assign vin_par[VI][i] = edge_par[CI][j];
            end
            rcapp_var_unit #(.R(R), .MAG_W(MAG_W), .LLR_W(LLR_W)) u_var (
                .clk   (clk),
                .rst_n (rst_n),
                .init  (init),
                .en    (var_en),
                .llr   (llr_q[VI*LLR_W +: LLR_W]),
                .vmag  (vin_mag[VI]),
                .vpar  (vin_par[VI]),
                .z_q   (z_q[VI]),
                .m_q   (m_q[VI])
            );
        end
    end

    assign bits_out = z_q;

endmodule

// File: rtl/rcapp_decoder_chk.sv
// Checker: port-level temporal properties of rcapp_decoder. It recomputes
// the syndrome of the output bits from the matrix wiring and counts the
// cycles of each run. It is bound to every instance of the top.
module rcapp_decoder_chk
    import rcapp_pkg::*;
#(
    parameter int P        = 5,
    parameter int R        = 3,
    parameter int C        = 5,
    parameter int MAX_ITER = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           converged,
    input logic [P*C-1:0] bits_out
);

    localparam logic [15:0] CAP_CYC = 16'(1 + 3 * MAX_ITER);

    logic [15:0]    run_cnt;
    logic [P*R-1:0] chk_synd;

    // Cycles elapsed since the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_cnt <= '0;
        else                 run_cnt <= run_cnt + 16'd1;
    end

    // Syndrome of the output bits from the circulant wiring.
    always_comb begin
        chk_synd = '0;
        for (int i = 0; i < R; i++)
            for (int a = 0; a < P; a++)
                for (int j = 0; j < C; j++)
                    chk_synd[i*P+a] = chk_synd[i*P+a] ^ bits_out[var_of(i, j, a, P)];
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_bits_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(bits_out));

    p_accept_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_conv_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converged) |-> done);

    p_conv_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && converged) |-> (chk_synd == '0));

    p_run_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt <= CAP_CYC && (run_cnt % 16'd3) == 16'd1));

endmodule

bind rcapp_decoder rcapp_decoder_chk #(
    .P(P), .R(R), .C(C), .MAX_ITER(MAX_ITER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .converged (converged),
    .bits_out  (bits_out)
);

// File: tb/sim_rcapp_decoder.sv
// Bench: behavioural integer model of the decoding rules plus an edge
// counter for timing, compared against the outputs on every falling edge.
module sim_rcapp_decoder;

    localparam int P = 5, R = 3, C = 5, LLR_W = 4, MAG_W = 4, MAX_ITER = 8;
    localparam int N = P * C;
    localparam int MAXM = 15;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [N*LLR_W-1:0]   llr_in = '0;
    logic                 busy, done, converged;
    logic [N-1:0]         bits_out;

    int errors = 0, checks = 0, cyc = 0, cap_runs = 0;

    rcapp_decoder #(.P(P), .R(R), .C(C), .LLR_W(LLR_W), .MAG_W(MAG_W),
                    .MAX_ITER(MAX_ITER)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .llr_in(llr_in),
        .busy(busy), .done(done), .converged(converged), .bits_out(bits_out));

    always #5 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference decoder (R3..R9): returns bits, converged flag, iteration count.
    task automatic model(input logic [N*LLR_W-1:0] f, output logic [N-1:0] ob,
                         output bit oc, output int ok);
        int chb[N], cmg[N], zz[N], mm[N], acc[N], vl[C];
        bit any;
        for (int v = 0; v < N; v++) begin
            chb[v] = int'(f[v*LLR_W+3]);
            cmg[v] = int'(f[v*LLR_W +: 3]);
            zz[v] = chb[v];
            mm[v] = cmg[v];
        end
        ok = MAX_ITER;
        oc = 1'b0;
        for (int it = 1; it <= MAX_ITER; it++) begin
            for (int v = 0; v < N; v++) acc[v] = cmg[v];
            for (int i = 0; i < R; i++)
                for (int a = 0; a < P; a++) begin
                    for (int j = 0; j < C; j++) vl[j] = j * P + (a + i * j) % P;
                    for (int j = 0; j < C; j++) begin
                        int mn, px, mg;
                        mn = 1000; px = 0;
                        for (int k = 0; k < C; k++)
                            if (k != j) begin
                                if (mm[vl[k]] < mn) mn = mm[vl[k]];
                                px = px ^ zz[vl[k]];
                            end
                        mg = (3 * mn + 4) / 8;
                        acc[vl[j]] += (px == chb[vl[j]]) ? mg : -mg;
                    end
                end
            for (int v = 0; v < N; v++) begin
                zz[v] = chb[v] ^ ((acc[v] < 0) ? 1 : 0);
                mm[v] = (acc[v] < 0) ? -acc[v] : acc[v];
                if (mm[v] > MAXM) mm[v] = MAXM;
            end
            any = 1'b0;
            for (int i = 0; i < R; i++)
                for (int a = 0; a < P; a++) begin
                    int s;
                    s = 0;
                    for (int j = 0; j < C; j++) s = s ^ zz[j * P + (a + i * j) % P];
                    if (s != 0) any = 1'b1;
                end
            if (!any) begin
                ok = it;
                oc = 1'b1;
                break;
            end
        end
        for (int v = 0; v < N; v++) ob[v] = zz[v][0];
    endtask

    // Timing model state.
    bit           m_run = 1'b0, pconv = 1'b0, hconv = 1'b0;
    int           t = 0, pk = 1;
    logic [N-1:0] pbits = '0, hbits = '0;

    // Edge-counting model: accepts start only when idle (R2).
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 1'b0; hbits = '0; hconv = 1'b0;
        end else if (m_run) begin
            t++;
            if (t == 2 + 3 * pk) begin
                m_run = 1'b0; hbits = pbits; hconv = pconv;
                if (pk == MAX_ITER && !pconv) cap_runs++;
            end
        end else if (start) begin
            model(llr_in, pbits, pconv, pk);
            t = 0;
            m_run = 1'b1;
        end
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 busy", busy, m_run);
            if (m_run) begin
                chk("R8/R9 done timing", done, t == 1 + 3 * pk);
                if (t >= 1 + 3 * pk) begin
                    chk("R8 R9 converged at done", converged, pconv);
                    chk("R3 R4 R5 R6 R7 bits at done", bits_out, pbits);
                end else
                    chk("R8 converged low while running", converged, 0);
            end else begin
                chk("R10 done idle", done, 0);
                chk("R10 converged hold", converged, hconv);
                chk("R10 bits hold", bits_out, hbits);
            end
        end
    end

    function automatic logic [N*LLR_W-1:0] uniform(input bit neg, input int mag);
        logic [N*LLR_W-1:0] f;
        for (int v = 0; v < N; v++) f[v*LLR_W +: LLR_W] = {neg, 3'(mag)};
        return f;
    endfunction

    function automatic logic [N*LLR_W-1:0] noisy(input int pct, input int lo);
        logic [N*LLR_W-1:0] f;
        for (int v = 0; v < N; v++) begin
            bit neg;
            neg = ($urandom_range(0, 99) < pct);
            f[v*LLR_W +: LLR_W] = {neg, 3'($urandom_range(lo, 7))};
        end
        return f;
    endfunction

    task automatic launch(input logic [N*LLR_W-1:0] f);
        @(negedge clk);
        llr_in = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [N*LLR_W-1:0] fa, fb;
        logic [N-1:0]       eb;
        bit                 ec;
        int                 ek;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset converged", converged, 0);
        chk("R1 reset bits", bits_out, 0);

        // Clean all-zero codeword.
        launch(uniform(1'b0, 6));
        wait_idle();
        chk("R8 clean frame converged", converged, 1);

        // One weak wrong sign on variable 7.
        fa = uniform(1'b0, 5);
        fa[7*LLR_W +: LLR_W] = 4'b1001;
        launch(fa);
        wait_idle();
        chk("R6 weak error corrected", bits_out, 0);

        // Uniform strong negative frame.
        launch(uniform(1'b1, 7));
        wait_idle();

        // Start during a run is ignored.
        fa = noisy(15, 2);
        fb = noisy(40, 1);
        launch(fa);
        repeat (2) @(negedge clk);
        llr_in = fb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        model(fa, eb, ec, ek);
        chk("R2 late start ignored, bits", bits_out, eb);
        chk("R2 late start ignored, converged", converged, ec);

        // Start held high across done: taken at the first idle cycle.
        @(negedge clk);
        llr_in = noisy(20, 1);
        start = 1'b1;
        @(negedge clk);
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        llr_in = uniform(1'b0, 3);
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // Noisy frames at several error rates.
        for (int n = 0; n < 48; n++) begin
            launch(noisy(10 + (n % 4) * 12, 1 + (n % 3)));
            wait_idle();
        end
        $display("info: %0d runs reached the iteration cap", cap_runs);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule